// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block is the hardwired control unit of a multicycle processor. It is a Moore state machine with 4-bit state codes. It steps the shared datapath through instruction fetch, operand decode and then a short path that depends on the instruction class. Each state raises a fixed group of datapath control points: the instruction-register load, the PC update and its source, the operand latches, the ALU source and operation, the result latch, the data-memory strobes, the memory-data latch and the register-file write controls.

The controller takes the 6-bit opcode from the instruction register and a register-equality flag from the datapath. It reads the opcode only in decode. It reads the equality flag only in the branch state, where the flag picks the PC source. Every other output depends on the current state alone. Class paths are one state long for branch, two states for register-register, OR-immediate and store, and three states for load. An instruction therefore takes 3, 4, 4 or 5 cycles.

Top module: `mcc_controller`

## Requirements
- R1: A synchronous active-high reset forces state 0000 (fetch). While in fetch, the only control output that is high is `ir_en`.
- R2: Fetch (0000) raises `ir_en`. The next state is always decode (0001).
- R3: Decode (0001) raises `a_en`, `b_en` and `e_en`. The next state comes from the opcode: 000100 goes to 0011, 000000 to 0100, 001101 to 0110, 100011 to 1000 and 101011 to 1011.
- R4: The register-register path is 0100 and then 0101. In 0100, `alu_op`=10 (function field), `alu_src_imm`=0 and `s_en`=1. In 0101, `reg_wr`=1, `reg_dst_rd`=1, `wb_from_mem`=0 and `pc_en`=1 with `pc_sel`=0. The state then returns to 0000.
- R5: The OR-immediate path is 0110 and then 0111. In 0110, `alu_op`=01 (OR), `alu_src_imm`=1, `imm_sign_ext`=0 and `s_en`=1. In 0111, `reg_wr`=1, `reg_dst_rd`=0, `wb_from_mem`=0 and `pc_en`=1 with `pc_sel`=0. The state then returns to 0000.
- R6: The load path is 1000, then 1001, then 1010. In 1000, `alu_op`=00 (add), `alu_src_imm`=1, `imm_sign_ext`=1 and `s_en`=1. In 1001, `mem_rd`=1 and `m_en`=1. In 1010, `reg_wr`=1, `reg_dst_rd`=0, `wb_from_mem`=1 and `pc_en`=1 with `pc_sel`=0.
- R7: The store path is 1011 and then 1100. In 1011, `alu_op`=00, `alu_src_imm`=1, `imm_sign_ext`=1 and `s_en`=1. In 1100, `mem_wr`=1 and `pc_en`=1 with `pc_sel`=0.
- R8: The branch state (0011) raises `pc_en` and drives `pc_sel` equal to `eq_flag`, where 1 selects the taken target. The state then returns to 0000. `pc_sel` is 0 in every other state.
- R9: In decode, any opcode not listed in R3 leads back to 0000. Over that instruction no update strobe is raised: `pc_en`, `reg_wr`, `mem_wr` and `s_en` all stay 0.
- R10: Counted from one fetch to the next, an instruction takes 3 cycles for branch, 4 for register-register and OR-immediate, 5 for load, 4 for store and 2 for an unknown opcode.
- R11: `mem_rd` and `mem_wr` are never high together, and `reg_wr` is high only together with `pc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| eq_flag | input | 1 | Operand equality flag from the datapath |
| state_o | output | 4 | Current state code |
| ir_en | output | 1 | Instruction register load |
| pc_en | output | 1 | PC update enable |
| pc_sel | output | 1 | PC source: 1 taken target, 0 PC+4 |
| a_en | output | 1 | Operand A latch enable |
| b_en | output | 1 | Operand B latch enable |
| e_en | output | 1 | Equality latch enable |
| alu_src_imm | output | 1 | ALU second operand: 1 immediate, 0 register B |
| imm_sign_ext | output | 1 | Immediate extension: 1 sign, 0 zero |
| alu_op | output | 2 | ALU operation: 00 add, 01 OR, 10 function field |
| s_en | output | 1 | ALU result latch enable |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe (stores B) |
| m_en | output | 1 | Memory data latch enable |
| reg_wr | output | 1 | Register file write enable |
| reg_dst_rd | output | 1 | Write destination: 1 rd, 0 rt |
| wb_from_mem | output | 1 | Write-back data: 1 memory latch, 0 ALU latch |

## Verification
All control outputs except `pc_sel` are a pure function of the state register. A new state is therefore visible one rising edge after the cycle whose inputs chose it. `pc_sel` follows `eq_flag` within the same cycle while the machine is in the branch state. The bench changes inputs on the falling edge and samples one time unit later, so it compares the current state's outputs against a bench model, and only then advances the model by one state. For the cycle-count requirement, the bench steps an instruction for exactly its expected number of cycles and then reads the state just after the next rising edge, where fetch must have returned.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int ST_W  = 4;
    localparam int OP_W  = 6;
    localparam int ALU_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH    = 4'b0000,
        ST_DECODE   = 4'b0001,
        ST_BRANCH   = 4'b0011,
        ST_RR_EXEC  = 4'b0100,
        ST_RR_WB    = 4'b0101,
        ST_ORI_EXEC = 4'b0110,
        ST_ORI_WB   = 4'b0111,
        ST_LD_ADDR  = 4'b1000,
        ST_LD_MEM   = 4'b1001,
        ST_LD_WB    = 4'b1010,
        ST_ST_ADDR  = 4'b1011,
        ST_ST_MEM   = 4'b1100
    } state_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD   = 2'b00,
        ALU_OR    = 2'b01,
        ALU_FUNCT = 2'b10
    } alu_op_e;

    localparam logic [OP_W-1:0] OP_RR  = 6'b000000;
    localparam logic [OP_W-1:0] OP_ORI = 6'b001101;
    localparam logic [OP_W-1:0] OP_LD  = 6'b100011;
    localparam logic [OP_W-1:0] OP_ST  = 6'b101011;
    localparam logic [OP_W-1:0] OP_BR  = 6'b000100;

    typedef struct packed {
        logic    ir_en;
        logic    pc_en;
        logic    pc_sel;
        logic    a_en;
        logic    b_en;
        logic    e_en;
        logic    alu_src_imm;
        logic    imm_sign_ext;
        alu_op_e alu_op;
        logic    s_en;
        logic    mem_rd;
        logic    mem_wr;
        logic    m_en;
        logic    reg_wr;
        logic    reg_dst_rd;
        logic    wb_from_mem;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        ir_en: 1'b0, pc_en: 1'b0, pc_sel: 1'b0, a_en: 1'b0, b_en: 1'b0,
        e_en: 1'b0, alu_src_imm: 1'b0, imm_sign_ext: 1'b0, alu_op: ALU_ADD,
        s_en: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, m_en: 1'b0, reg_wr: 1'b0,
        reg_dst_rd: 1'b0, wb_from_mem: 1'b0
    };

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return (op == OP_RR) || (op == OP_ORI) || (op == OP_LD) ||
               (op == OP_ST) || (op == OP_BR);
    endfunction

    function automatic state_e class_entry(input logic [OP_W-1:0] op);
        state_e s;
        case (op)
            OP_BR:   s = ST_BRANCH;
            OP_RR:   s = ST_RR_EXEC;
            OP_ORI:  s = ST_ORI_EXEC;
            OP_LD:   s = ST_LD_ADDR;
            OP_ST:   s = ST_ST_ADDR;
            default: s = ST_FETCH;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
    import mcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e nxt,
    output state_e cur
);

    always_ff @(posedge clk) begin
        if (rst) cur <= ST_FETCH;
        else     cur <= nxt;
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e          cur,
    input  logic [OP_W-1:0] opcode,
    output state_e          nxt
);

    always_comb begin
        case (cur)
            ST_FETCH:    nxt = ST_DECODE;
            ST_DECODE:   nxt = class_entry(opcode);
            ST_RR_EXEC:  nxt = ST_RR_WB;
            ST_ORI_EXEC: nxt = ST_ORI_WB;
            ST_LD_ADDR:  nxt = ST_LD_MEM;
            ST_LD_MEM:   nxt = ST_LD_WB;
            ST_ST_ADDR:  nxt = ST_ST_MEM;
            default:     nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  state_e cur,
    input  logic   eq_flag,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = CTRL_IDLE;
        case (cur)
            ST_FETCH: ctrl.ir_en = 1'b1;
            ST_DECODE: begin
                ctrl.a_en = 1'b1;
                ctrl.b_en = 1'b1;
                ctrl.e_en = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.pc_en  = 1'b1;
                ctrl.pc_sel = eq_flag;
            end
            ST_RR_EXEC: begin
                ctrl.alu_op = ALU_FUNCT;
                ctrl.s_en   = 1'b1;
            end
            ST_RR_WB: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.reg_dst_rd = 1'b1;
                ctrl.pc_en      = 1'b1;
            end
            ST_ORI_EXEC: begin
                ctrl.alu_op      = ALU_OR;
                ctrl.alu_src_imm = 1'b1;
                ctrl.s_en        = 1'b1;
            end
            ST_ORI_WB: begin
                ctrl.reg_wr = 1'b1;
                ctrl.pc_en  = 1'b1;
            end
            ST_LD_ADDR, ST_ST_ADDR: begin
                ctrl.alu_op       = ALU_ADD;
                ctrl.alu_src_imm  = 1'b1;
                ctrl.imm_sign_ext = 1'b1;
                ctrl.s_en         = 1'b1;
            end
            ST_LD_MEM: begin
                ctrl.mem_rd = 1'b1;
                ctrl.m_en   = 1'b1;
            end
            ST_LD_WB: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.pc_en       = 1'b1;
            end
            ST_ST_MEM: begin
                ctrl.mem_wr = 1'b1;
                ctrl.pc_en  = 1'b1;
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/mcc_controller.sv
module mcc_controller
    import mcc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [mcc_pkg::OP_W-1:0]   opcode,
    input  logic                       eq_flag,
    output logic [mcc_pkg::ST_W-1:0]   state_o,
    output logic                       ir_en,
    output logic                       pc_en,
    output logic                       pc_sel,
    output logic                       a_en,
    output logic                       b_en,
    output logic                       e_en,
    output logic                       alu_src_imm,
    output logic                       imm_sign_ext,
    output logic [mcc_pkg::ALU_W-1:0]  alu_op,
    output logic                       s_en,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic                       m_en,
    output logic                       reg_wr,
    output logic                       reg_dst_rd,
    output logic                       wb_from_mem
);

    state_e cur_state;
    state_e nxt_state;
    ctrl_t  ctrl;

    mcc_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_state),
        .cur (cur_state)
    );

    mcc_next_state u_next (
        .cur    (cur_state),
        .opcode (opcode),
        .nxt    (nxt_state)
    );

    mcc_ctrl_decode u_dec (
        .cur     (cur_state),
        .eq_flag (eq_flag),
        .ctrl    (ctrl)
    );

    assign state_o      = cur_state;
    assign ir_en        = ctrl.ir_en;
    assign pc_en        = ctrl.pc_en;
    assign pc_sel       = ctrl.pc_sel;
    assign a_en         = ctrl.a_en;
    assign b_en         = ctrl.b_en;
    assign e_en         = ctrl.e_en;
    assign alu_src_imm  = ctrl.alu_src_imm;
    assign imm_sign_ext = ctrl.imm_sign_ext;
    assign alu_op       = ctrl.alu_op;
    assign s_en         = ctrl.s_en;
    assign mem_rd       = ctrl.mem_rd;
    assign mem_wr       = ctrl.mem_wr;
    assign m_en         = ctrl.m_en;
    assign reg_wr       = ctrl.reg_wr;
    assign reg_dst_rd   = ctrl.reg_dst_rd;
    assign wb_from_mem  = ctrl.wb_from_mem;

    AST_RESET_TO_FETCH: assert property (@(posedge clk)
        rst |=> cur_state == ST_FETCH); // R1
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        cur_state == ST_FETCH |=> cur_state == ST_DECODE); // R2
    AST_DECODE_ENABLES: assert property (@(posedge clk) disable iff (rst)
        cur_state == ST_DECODE |-> (a_en && b_en && e_en && !pc_en)); // R3
    AST_RR_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        cur_state == ST_RR_EXEC |=> (cur_state == ST_RR_WB && reg_dst_rd)); // R4
    AST_ORI_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        cur_state == ST_ORI_EXEC |=> (cur_state == ST_ORI_WB && !reg_dst_rd)); // R5
    AST_LOAD_MEM_STEP: assert property (@(posedge clk) disable iff (rst)
        cur_state == ST_LD_ADDR |=> (mem_rd && m_en)); // R6
    AST_LOAD_WB_STEP: assert property (@(posedge clk) disable iff (rst)
        cur_state == ST_LD_MEM |=> (reg_wr && wb_from_mem)); // R6
    AST_STORE_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        cur_state == ST_ST_ADDR |=> (mem_wr && pc_en)); // R7
    AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (rst)
        cur_state == ST_BRANCH |=> cur_state == ST_FETCH); // R8
    AST_PC_SEL_ONLY_BRANCH: assert property (@(posedge clk) disable iff (rst)
        pc_sel |-> (cur_state == ST_BRANCH && eq_flag)); // R8
    AST_UNKNOWN_OP_FETCH: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_DECODE && !op_known(opcode)) |=>
        (cur_state == ST_FETCH && !pc_en && !reg_wr && !mem_wr)); // R9
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R11
    AST_WB_WITH_PC: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> pc_en); // R11

endmodule

// File: tb/mcc_controller_tb.sv
module mcc_controller_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic       eq_flag = 1'b0;
    logic [3:0] state_o;
    logic       ir_en, pc_en, pc_sel, a_en, b_en, e_en;
    logic       alu_src_imm, imm_sign_ext, s_en;
    logic [1:0] alu_op;
    logic       mem_rd, mem_wr, m_en, reg_wr, reg_dst_rd, wb_from_mem;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [3:0] model = 4'b0000;
    logic [5:0] last_op = 6'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcc_controller u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .eq_flag(eq_flag),
        .state_o(state_o), .ir_en(ir_en), .pc_en(pc_en), .pc_sel(pc_sel),
        .a_en(a_en), .b_en(b_en), .e_en(e_en), .alu_src_imm(alu_src_imm),
        .imm_sign_ext(imm_sign_ext), .alu_op(alu_op), .s_en(s_en),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .m_en(m_en), .reg_wr(reg_wr),
        .reg_dst_rd(reg_dst_rd), .wb_from_mem(wb_from_mem)
    );

    function automatic logic [3:0] exp_next(input logic [3:0] s, input logic [5:0] op);
        case (s)
            4'b0000: return 4'b0001;
            4'b0001: case (op)
                6'b000100: return 4'b0011;
                6'b000000: return 4'b0100;
                6'b001101: return 4'b0110;
                6'b100011: return 4'b1000;
                6'b101011: return 4'b1011;
                default:   return 4'b0000;
            endcase
            4'b0100: return 4'b0101;
            4'b0110: return 4'b0111;
            4'b1000: return 4'b1001;
            4'b1001: return 4'b1010;
            4'b1011: return 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    // order: ir pc sel a b e src sext op[1:0] s rd wr m regwr dst wbm
    function automatic logic [17:0] exp_ctrl(input logic [3:0] s, input logic eq);
        logic ir, pe, ps, a, b, e, src, sx, se, rd, wr, m, rw, dst, wbm;
        logic [1:0] op;
        {ir, pe, ps, a, b, e, src, sx, se, rd, wr, m, rw, dst, wbm} = '0;
        op = 2'b00;
        case (s)
            4'b0000: ir = 1'b1;
            4'b0001: begin a = 1'b1; b = 1'b1; e = 1'b1; end
            4'b0011: begin pe = 1'b1; ps = eq; end
            4'b0100: begin op = 2'b10; se = 1'b1; end
            4'b0101: begin rw = 1'b1; dst = 1'b1; pe = 1'b1; end
            4'b0110: begin op = 2'b01; src = 1'b1; se = 1'b1; end
            4'b0111: begin rw = 1'b1; pe = 1'b1; end
            4'b1000, 4'b1011: begin src = 1'b1; sx = 1'b1; se = 1'b1; end
            4'b1001: begin rd = 1'b1; m = 1'b1; end
            4'b1010: begin rw = 1'b1; wbm = 1'b1; pe = 1'b1; end
            4'b1100: begin wr = 1'b1; pe = 1'b1; end
            default: ;
        endcase
        return {ir, pe, ps, a, b, e, src, sx, op, se, rd, wr, m, rw, dst, wbm};
    endfunction

    function automatic string req_tag(input logic [3:0] s, input logic [5:0] op);
        case (s)
            4'b0000: return "R2";
            4'b0001: return (op == 6'b000100 || op == 6'b000000 || op == 6'b001101 ||
                             op == 6'b100011 || op == 6'b101011) ? "R3" : "R9";
            4'b0011: return "R8";
            4'b0100, 4'b0101: return "R4";
            4'b0110, 4'b0111: return "R5";
            4'b1000, 4'b1001, 4'b1010: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [17:0] dut_ctrl();
        return {ir_en, pc_en, pc_sel, a_en, b_en, e_en, alu_src_imm, imm_sign_ext,
                alu_op, s_en, mem_rd, mem_wr, m_en, reg_wr, reg_dst_rd, wb_from_mem};
    endfunction

    task automatic check_now(input string tag);
        logic [17:0] exp_c;
        exp_c = exp_ctrl(model, eq_flag);
        n_chk++;
        if (state_o !== model) begin
            n_bad++;
            $display("FAIL %s state actual=%b expected=%b", tag, state_o, model);
        end
        n_chk++;
        if (dut_ctrl() !== exp_c) begin
            n_bad++;
            $display("FAIL %s controls in state %b actual=%b expected=%b",
                     tag, model, dut_ctrl(), exp_c);
        end
        // R11 strobe rules checked at the ports
        n_chk++;
        if ((mem_rd && mem_wr) || (reg_wr && !pc_en)) begin
            n_bad++;
            $display("FAIL R11 strobes actual=%b%b%b%b expected=no overlap",
                     mem_rd, mem_wr, reg_wr, pc_en);
        end
    endtask

    task automatic step(input logic [5:0] op, input logic eq);
        @(negedge clk);
        rst = 1'b0;
        opcode = op;
        eq_flag = eq;
        #1;
        check_now(req_tag(model, op));
        model = exp_next(model, op);
    endtask

    // R10: step exactly cpi cycles, then fetch must be back after the next edge
    task automatic run_instr(input logic [5:0] op, input logic eq, input int cpi);
        for (int i = 0; i < cpi; i++) step(op, eq);
        @(posedge clk);
        #1;
        n_chk++;
        if (state_o !== 4'b0000) begin
            n_bad++;
            $display("FAIL R10 op=%b state after %0d cycles actual=%b expected=0000",
                     op, cpi, state_o);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED_0042);

        // R1 reset state
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        model = 4'b0000;
        check_now("R1");

        run_instr(6'b000100, 1'b1, 3); // R8 taken
        run_instr(6'b000100, 1'b0, 3); // R8 not taken
        run_instr(6'b000000, 1'b1, 4); // R4
        run_instr(6'b001101, 1'b0, 4); // R5
        run_instr(6'b100011, 1'b1, 5); // R6
        run_instr(6'b101011, 1'b0, 4); // R7
        run_instr(6'b111111, 1'b1, 2); // R9 unknown opcode
        run_instr(6'b000101, 1'b0, 2); // R9 near-branch code

        // R1 reset in the middle of a load
        step(6'b100011, 1'b0);
        step(6'b100011, 1'b0);
        step(6'b100011, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        model = 4'b0000;
        check_now("R1");

        // random instruction mix, opcode and flag change every cycle
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op;
            case ($urandom % 8)
                0: op = 6'b000000;
                1: op = 6'b001101;
                2: op = 6'b100011;
                3: op = 6'b101011;
                4: op = 6'b000100;
                default: op = 6'($urandom);
            endcase
            last_op = op;
            step(op, 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule